// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block is an SPI master that runs read, page-program and sector-erase requests against a bank of serial NOR flash devices. Each device has its own active-low select line. A single request port takes an operation code, a 24-bit global byte address and a byte count. The global address space is split into equal device regions of `2**CHIP_AW` bytes. The address bits above the region bits pick the device, and the bits below them are sent as the device-local address. Program data enters through a valid/ready byte stream. Read data leaves through a second valid/ready byte stream. When the request finishes, the block gives a one-cycle response pulse with an error flag.

Program and erase both need a write-enable frame first. The block sends it in its own chip-select frame and marks the target device as possibly busy. The block does not wait for the write to finish. It polls the device's status register only when a later request targets that same device. Requests to other devices therefore proceed at once, with no status traffic.

The serial clock runs in SPI mode 0. SCLK idles low and each phase lasts `CLK_DIV` system cycles, so the serial clock period is at least two system cycles.

Top module: `nor_cmd_seq`

## Requirements
- R1: The command frame is one opcode byte (read 0x03, page program 0x02, sector erase 0xD8) followed by the device-local address in three bytes, most significant byte first.
- R2: Every program and every erase is preceded by a write-enable frame. That frame carries the single byte 0x06 and ends with chip select raised before the command frame begins.
- R3: The write-enable frame marks its device pending. The next request to a pending device first runs one status frame: opcode 0x05, then status bytes read repeatedly until bit 0 reads 0. Only after that does the pending mark clear. Requests to a device that is not pending send no status frame.
- R4: SPI mode 0. SCLK is low whenever no device is selected. Each SCLK high phase lasts `CLK_DIV` system cycles. MOSI changes only while SCLK is low. Bytes are sent MSB first.
- R5: A read returns exactly `req_len` bytes on `rd_data`, in rising address order, while chip select stays low. MOSI carries 0xFF during the data bytes. A byte that has been offered holds `rd_valid` and `rd_data` steady until `rd_ready`.
- R6: A program takes exactly `req_len` bytes from the write stream and sends them in order after the address.
- R7: A read or program with a length of 0, or whose address plus length exceeds `NUM_CHIPS * 2**CHIP_AW`, is rejected. So is an erase whose address is at or beyond that total. A rejected request gets `rsp_err`=1 and causes no chip-select activity. A request that ends exactly at the total is accepted.
- R8: A program whose bytes would cross a 256-byte page boundary (address bits 7:0 plus length greater than 256) is rejected. A program that ends exactly at the page end is accepted.
- R9: At most one chip select is low at any time. Device index = `req_addr[CHIP_AW +: log2(NUM_CHIPS)]`, and `cs_n[i]` selects device i.
- R10: `req_ready` is high only while the block is idle, and all chip selects are high then. Completion gives a one-cycle `rsp_valid` with `rsp_err`=0.
- R11: Operation code 3 (`req_op` encoding: 0 read, 1 program, 2 erase) is reserved and is rejected like R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_addr | input | 24 | Global byte address |
| req_len | input | LEN_W | Byte count (ignored for erase) |
| wr_valid | input | 1 | Program data byte offered |
| wr_ready | output | 1 | Program data byte taken |
| wr_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte offered |
| rd_ready | input | 1 | Read data byte taken |
| rd_data | output | 8 | Read data byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Request rejected, valid with rsp_valid |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the devices |
| cs_n | output | NUM_CHIPS | Active-low select, one per device |
| miso | input | 1 | Serial data from the selected device |

## Verification
Two functions can fall in the same cycle. One is the completion of a shifted read byte. The other is the hand-off of the previous byte on the read stream, while the serializer would also like to launch the next byte. The bench provokes this by holding `rd_ready` low across several byte times of a multi-byte read and then releasing it. It judges the result by the order and count of the delivered bytes, and by `rd_valid` staying high with stable data during the stall. A second overlap is a program or erase leaving one device pending while a request arrives for the other device. The bench's device model records each frame and counts any data command that reaches a device still reporting write-in-progress. A zero count, together with the absence of status frames on the idle device, judges the deferred polling.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } nor_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_OP, S_POLL_RD, S_GAP, S_WREN, S_WGAP,
    S_CMD, S_WDATA, S_RDATA, S_DRAIN, S_DONE
  } seq_state_e;

  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_PROG  = 8'h02;
  localparam logic [7:0] CMD_ERASE = 8'hD8;
  localparam logic [7:0] CMD_WREN  = 8'h06;
  localparam logic [7:0] CMD_RDSR  = 8'h05;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam int         WIP_BIT   = 0;
  localparam int         PAGE_BYTES = 256;

endpackage

// File: rtl/nor_bit_shifter.sv
module nor_bit_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] HC_LAST = CW'(CLK_DIV - 1);

  logic          active_q, active_d;
  logic          sclk_q, sclk_d;
  logic [CW-1:0] hcnt_q, hcnt_d;
  logic [2:0]    bitn_q, bitn_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          done_q, done_d;

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    hcnt_d   = hcnt_q;
    bitn_d   = bitn_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (start) begin
        active_d = 1'b1;
        tx_d     = tx_byte;
        hcnt_d   = '0;
        bitn_d   = '0;
        sclk_d   = 1'b0;
      end
    end else if (hcnt_q == HC_LAST) begin
      hcnt_d = '0;
      if (!sclk_q) begin
        sclk_d = 1'b1;
        rx_d   = {rx_q[6:0], miso};
      end else begin
        sclk_d = 1'b0;
        if (bitn_q == 3'd7) begin
          active_d = 1'b0;
          done_d   = 1'b1;
        end else begin
          bitn_d = bitn_q + 3'd1;
          tx_d   = {tx_q[6:0], 1'b1};
        end
      end
    end else begin
      hcnt_d = hcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      hcnt_q   <= '0;
      bitn_q   <= '0;
      tx_q     <= 8'hFF;
      rx_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      hcnt_q   <= hcnt_d;
      bitn_q   <= bitn_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];
  assign busy    = active_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/nor_busy_track.sv
module nor_busy_track #(
  parameter int NUM_CHIPS = 2,
  localparam int IW = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_en,
  input  logic [IW-1:0]        set_idx,
  input  logic                 clr_en,
  input  logic [IW-1:0]        clr_idx,
  output logic [NUM_CHIPS-1:0] pend
);
  for (genvar gi = 0; gi < NUM_CHIPS; gi++) begin : g_chip
    logic pend_d;
    always_comb begin
      pend_d = pend[gi];
      if (set_en && (set_idx == IW'(gi)))      pend_d = 1'b1;
      else if (clr_en && (clr_idx == IW'(gi))) pend_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[gi] <= 1'b0;
      else        pend[gi] <= pend_d;
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int NUM_CHIPS = 2,
  parameter int CHIP_AW   = 18,
  parameter int LEN_W     = 12,
  parameter int CLK_DIV   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [23:0]          req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [7:0]           wr_data,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [7:0]           rd_data,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic                 sclk,
  output logic                 mosi,
  output logic [NUM_CHIPS-1:0] cs_n,
  input  logic                 miso
);
  localparam int CS_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
  localparam logic [24:0] TOTAL_B = 25'(NUM_CHIPS) << CHIP_AW;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_e          st_q, st_d;
  nor_op_e             op_q, op_d;
  logic [CS_W-1:0]     chip_q, chip_d;
  logic [23:0]         laddr_q, laddr_d;
  logic [LEN_W-1:0]    cnt_q, cnt_d;
  logic [1:0]          bidx_q, bidx_d;
  logic                issued_q, issued_d;
  logic                rdv_q, rdv_d;
  logic [7:0]          rdd_q, rdd_d;
  logic                rspv_q, rspv_d;
  logic                rspe_q, rspe_d;
  logic [NUM_CHIPS-1:0] cs_n_q, cs_n_d;

  logic       sh_start, sh_busy, sh_done;
  logic [7:0] sh_tx, sh_rx;
  logic [NUM_CHIPS-1:0] pend;
  logic       set_en, clr_en;

  nor_bit_shifter #(.CLK_DIV(CLK_DIV)) u_shifter (
    .clk(clk), .rst_n(rst_int_n), .start(sh_start), .tx_byte(sh_tx),
    .miso(miso), .sclk(sclk), .mosi(mosi), .busy(sh_busy),
    .done(sh_done), .rx_byte(sh_rx)
  );

  nor_busy_track #(.NUM_CHIPS(NUM_CHIPS)) u_busy (
    .clk(clk), .rst_n(rst_int_n), .set_en(set_en), .set_idx(chip_q),
    .clr_en(clr_en), .clr_idx(chip_q), .pend(pend)
  );

  // request screening
  logic [CS_W-1:0] req_chip;
  logic [24:0]     req_end;
  logic [12:0]     page_end;
  logic            req_bad;
  assign req_chip = req_addr[CHIP_AW +: CS_W];
  assign req_end  = {1'b0, req_addr} + 25'(req_len);
  assign page_end = 13'(req_addr[7:0]) + 13'(req_len);

  always_comb begin
    case (nor_op_e'(req_op))
      OP_READ:  req_bad = (req_len == '0) || (req_end > TOTAL_B);
      OP_PROG:  req_bad = (req_len == '0) || (req_end > TOTAL_B) ||
                          (page_end > 13'(PAGE_BYTES));
      OP_ERASE: req_bad = ({1'b0, req_addr} >= TOTAL_B);
      default:  req_bad = 1'b1;
    endcase
  end

  // byte launch and transmit byte selection
  logic byte_state;
  assign byte_state = (st_q == S_POLL_OP) || (st_q == S_POLL_RD) ||
                      (st_q == S_WREN)    || (st_q == S_CMD)     ||
                      (st_q == S_WDATA)   || (st_q == S_RDATA);
  assign sh_start = byte_state && !issued_q && !sh_busy &&
                    ((st_q != S_WDATA) || wr_valid) &&
                    ((st_q != S_RDATA) || !rdv_q);
  assign wr_ready = (st_q == S_WDATA) && !issued_q && !sh_busy;

  always_comb begin
    case (st_q)
      S_POLL_OP: sh_tx = CMD_RDSR;
      S_WREN:    sh_tx = CMD_WREN;
      S_WDATA:   sh_tx = wr_data;
      S_CMD: begin
        case (bidx_q)
          2'd0: begin
            case (op_q)
              OP_PROG:  sh_tx = CMD_PROG;
              OP_ERASE: sh_tx = CMD_ERASE;
              default:  sh_tx = CMD_READ;
            endcase
          end
          2'd1:    sh_tx = laddr_q[23:16];
          2'd2:    sh_tx = laddr_q[15:8];
          default: sh_tx = laddr_q[7:0];
        endcase
      end
      default:   sh_tx = FILL_BYTE;
    endcase
  end

  // sequencing
  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    chip_d   = chip_q;
    laddr_d  = laddr_q;
    cnt_d    = cnt_q;
    bidx_d   = bidx_q;
    issued_d = issued_q;
    rdv_d    = rdv_q;
    rdd_d    = rdd_q;
    rspv_d   = 1'b0;
    rspe_d   = rspe_q;
    set_en   = 1'b0;
    clr_en   = 1'b0;
    if (rdv_q && rd_ready) rdv_d = 1'b0;
    if (sh_start) issued_d = 1'b1;
    if (byte_state && sh_done) issued_d = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          if (req_bad) begin
            rspv_d = 1'b1;
            rspe_d = 1'b1;
          end else begin
            op_d    = nor_op_e'(req_op);
            chip_d  = req_chip;
            laddr_d = 24'(req_addr[CHIP_AW-1:0]);
            cnt_d   = req_len;
            bidx_d  = 2'd0;
            if (pend[req_chip])                   st_d = S_POLL_OP;
            else if (nor_op_e'(req_op) == OP_READ) st_d = S_CMD;
            else                                  st_d = S_WREN;
          end
        end
      end
      S_POLL_OP: if (sh_done) st_d = S_POLL_RD;
      S_POLL_RD: begin
        if (sh_done && !sh_rx[WIP_BIT]) begin
          clr_en = 1'b1;
          st_d   = S_GAP;
        end
      end
      S_GAP:  st_d = (op_q == OP_READ) ? S_CMD : S_WREN;
      S_WREN: begin
        if (sh_done) begin
          set_en = 1'b1;
          st_d   = S_WGAP;
        end
      end
      S_WGAP: st_d = S_CMD;
      S_CMD: begin
        if (sh_done) begin
          if (bidx_q == 2'd3) begin
            case (op_q)
              OP_READ: st_d = S_RDATA;
              OP_PROG: st_d = S_WDATA;
              default: st_d = S_DONE;
            endcase
          end else begin
            bidx_d = bidx_q + 2'd1;
          end
        end
      end
      S_WDATA: begin
        if (sh_done) begin
          cnt_d = cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) st_d = S_DONE;
        end
      end
      S_RDATA: begin
        if (sh_done) begin
          rdv_d = 1'b1;
          rdd_d = sh_rx;
          cnt_d = cnt_q - LEN_W'(1);
          if (cnt_q == LEN_W'(1)) st_d = S_DRAIN;
        end
      end
      S_DRAIN: if (!rdv_q) st_d = S_DONE;
      S_DONE: begin
        rspv_d = 1'b1;
        rspe_d = 1'b0;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // chip select follows the next state so it is a clean register output
  logic sel_low;
  assign sel_low = (st_d == S_POLL_OP) || (st_d == S_POLL_RD) ||
                   (st_d == S_WREN)    || (st_d == S_CMD)     ||
                   (st_d == S_WDATA)   || (st_d == S_RDATA);
  always_comb begin
    for (int i = 0; i < NUM_CHIPS; i++) begin
      cs_n_d[i] = !(sel_low && (chip_d == CS_W'(i)));
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q     <= S_IDLE;
      op_q     <= OP_READ;
      chip_q   <= '0;
      laddr_q  <= '0;
      cnt_q    <= '0;
      bidx_q   <= '0;
      issued_q <= 1'b0;
      rdv_q    <= 1'b0;
      rdd_q    <= '0;
      rspv_q   <= 1'b0;
      rspe_q   <= 1'b0;
      cs_n_q   <= '1;
    end else begin
      st_q     <= st_d;
      op_q     <= op_d;
      chip_q   <= chip_d;
      laddr_q  <= laddr_d;
      cnt_q    <= cnt_d;
      bidx_q   <= bidx_d;
      issued_q <= issued_d;
      rdv_q    <= rdv_d;
      rdd_q    <= rdd_d;
      rspv_q   <= rspv_d;
      rspe_q   <= rspe_d;
      cs_n_q   <= cs_n_d;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign rsp_valid = rspv_q;
  assign rsp_err   = rspe_q;
  assign cs_n      = cs_n_q;
endmodule

// File: rtl/nor_seq_checker.sv
module nor_seq_checker #(
  parameter int NUM_CHIPS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CHIPS-1:0] cs_n,
  input logic                 sclk,
  input logic                 mosi,
  input logic                 req_ready,
  input logic                 rd_valid,
  input logic                 rd_ready,
  input logic [7:0]           rd_data,
  input logic                 rsp_valid,
  input logic                 rsp_err
);
  assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sclk);

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (&cs_n));

  assert_idle_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&cs_n));
endmodule

bind nor_cmd_seq nor_seq_checker #(.NUM_CHIPS(NUM_CHIPS)) u_nor_seq_checker (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .req_ready(req_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/test_nor_cmd_seq.sv
`timescale 1ns/1ps
module test_nor_cmd_seq;
  localparam int LEN_W = 12;

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [1:0] req_op;
  logic [23:0] req_addr;
  logic [LEN_W-1:0] req_len;
  logic wr_valid, wr_ready;
  logic [7:0] wr_data;
  logic rd_valid, rd_ready;
  logic [7:0] rd_data;
  logic rsp_valid, rsp_err, sclk, mosi, miso;
  logic [1:0] cs_n;

  nor_cmd_seq #(.NUM_CHIPS(2), .CHIP_AW(18), .LEN_W(LEN_W), .CLK_DIV(2)) i_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .miso(miso)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  wire any_sel = ~&cs_n;
  logic [7:0] m_in, m_out, m_next, m_op;
  int m_bit, m_idx, m_chip;
  logic [23:0] m_addr;
  int busy_cnt [2];
  bit wel [2];
  int viol = 0, fill_bad = 0, sel_falls = 0;
  int fr_n = 0;
  logic [7:0] fr_op [64];
  int fr_chip [64], fr_bytes [64];
  logic [23:0] fr_addr [64];
  logic [7:0] pdata [256];
  int pn;

  function automatic logic [7:0] fdat(input logic [23:0] a, input int c);
    return a[7:0] ^ 8'h3C ^ 8'(c);
  endfunction

  initial begin
    miso = 1'b0; m_next = 8'h00; m_out = 8'h00;
    busy_cnt[0] = 0; busy_cnt[1] = 0; wel[0] = 0; wel[1] = 0;
  end

  always @(posedge any_sel) begin
    sel_falls++;
    m_bit = 0; m_idx = 0; pn = 0;
    m_chip = cs_n[0] ? 1 : 0;
  end

  always @(negedge any_sel) begin
    fr_op[fr_n] = m_op; fr_chip[fr_n] = m_chip;
    fr_bytes[fr_n] = m_idx; fr_addr[fr_n] = m_addr;
    fr_n++;
    if (m_op == 8'h06 && m_idx == 1) wel[m_chip] = 1;
    if ((m_op == 8'h02 || m_op == 8'hD8) && m_idx >= 4) begin
      if (!wel[m_chip]) viol++;
      wel[m_chip] = 0;
      busy_cnt[m_chip] = 3;
    end
  end

  always @(posedge sclk) if (any_sel) begin
    m_in = {m_in[6:0], mosi};
    m_bit++;
    if (m_bit == 8) begin
      m_bit = 0;
      if (m_idx == 0) begin
        m_op = m_in;
        if ((m_in == 8'h03 || m_in == 8'h02 || m_in == 8'hD8) && busy_cnt[m_chip] > 0) viol++;
      end else if (m_idx <= 3) begin
        m_addr = {m_addr[15:0], m_in};
      end else begin
        if (m_op == 8'h02) begin pdata[pn] = m_in; pn++; end
        if (m_op == 8'h03 && m_in != 8'hFF) fill_bad++;
      end
      if (m_op == 8'h05) begin
        m_next = {6'b0, wel[m_chip], busy_cnt[m_chip] > 0};
        if (busy_cnt[m_chip] > 0) busy_cnt[m_chip]--;
      end else if (m_op == 8'h03 && m_idx >= 3) begin
        m_next = fdat(m_addr + 24'(m_idx - 3), m_chip);
      end
      m_idx++;
    end
  end

  always @(negedge sclk) if (any_sel) begin
    if (m_bit == 0) m_out = m_next;
    else            m_out = {m_out[6:0], 1'b0};
    miso = m_out[7];
  end

  // ---------------- observers ----------------
  logic [7:0] rd_got [256];
  int rd_n = 0;
  always @(negedge clk) if (rd_valid && rd_ready) begin
    rd_got[rd_n] = rd_data; rd_n++;
  end

  int hi_run = 0, hi_min = 1000, hi_max = 0;
  always @(negedge clk) begin
    if (sclk) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // ---------------- drivers ----------------
  logic [7:0] wq [256];

  task automatic do_req(input logic [1:0] op, input logic [23:0] a, input int len, output bit err);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = LEN_W'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    err = rsp_err;
  endtask

  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      wr_data = wq[i]; wr_valid = 1'b1;
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    wr_valid = 1'b0;
  endtask

  task automatic prog_req(input logic [23:0] a, input int n, output bit err);
    bit e;
    fork
      do_req(2'd1, a, n, e);
      feed(n);
    join
    err = e;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(cs_n == 2'b11, "R10 reset cs_n", int'(cs_n), 3);
    chk(sclk == 1'b0, "R4 reset sclk", int'(sclk), 0);
    chk(req_ready == 1'b1, "R10 reset req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0 && rd_valid == 1'b0, "R10 reset outputs", int'({rsp_valid, rd_valid}), 0);
  endtask

  task automatic t_read_plain;
    bit e; int f0 = fr_n;
    rd_n = 0;
    do_req(2'd0, 24'h000120, 4, e);
    chk(!e, "R10 read ok", int'(e), 0);
    chk(fr_n == f0 + 1, "R3 no status frame on idle chip", fr_n - f0, 1);
    chk(fr_op[f0] == 8'h03 && fr_addr[f0] == 24'h000120, "R1 read frame", int'(fr_addr[f0]), 'h120);
    chk(fr_bytes[f0] == 8, "R5 read frame length", fr_bytes[f0], 8);
    chk(rd_n == 4, "R5 read count", rd_n, 4);
    for (int i = 0; i < 4; i++)
      chk(rd_got[i] == fdat(24'h000120 + 24'(i), 0), "R5 read data", int'(rd_got[i]),
          int'(fdat(24'h000120 + 24'(i), 0)));
  endtask

  task automatic t_program;
    bit e; int f0 = fr_n;
    wq[0] = 8'hAA; wq[1] = 8'h55; wq[2] = 8'h0F;
    prog_req(24'h040010, 3, e);
    chk(!e, "R10 program ok", int'(e), 0);
    chk(fr_n == f0 + 2, "R2 program frame count", fr_n - f0, 2);
    chk(fr_op[f0] == 8'h06 && fr_bytes[f0] == 1 && fr_chip[f0] == 1, "R2 write enable frame",
        int'(fr_op[f0]), 'h06);
    chk(fr_op[f0+1] == 8'h02 && fr_chip[f0+1] == 1, "R9 program on chip 1", fr_chip[f0+1], 1);
    chk(fr_addr[f0+1] == 24'h000010 && fr_bytes[f0+1] == 7, "R1 program address", int'(fr_addr[f0+1]), 'h10);
    chk(pdata[0] == 8'hAA && pdata[1] == 8'h55 && pdata[2] == 8'h0F, "R6 program data",
        int'({pdata[0], pdata[1], pdata[2]}), 'hAA550F);
  endtask

  task automatic t_other_chip;
    bit e; int f0 = fr_n;
    rd_n = 0;
    do_req(2'd0, 24'h000200, 2, e);
    chk(!e && fr_n == f0 + 1 && fr_op[f0] == 8'h03, "R3 other chip not polled", fr_n - f0, 1);
  endtask

  task automatic t_poll;
    bit e; int f0 = fr_n;
    rd_n = 0;
    do_req(2'd0, 24'h040010, 3, e);
    chk(!e, "R3 read after program ok", int'(e), 0);
    chk(fr_n == f0 + 2, "R3 poll frame count", fr_n - f0, 2);
    chk(fr_op[f0] == 8'h05 && fr_chip[f0] == 1, "R3 status opcode", int'(fr_op[f0]), 'h05);
    chk(fr_bytes[f0] == 5, "R3 status bytes until clear", fr_bytes[f0], 5);
    chk(fr_op[f0+1] == 8'h03, "R3 read follows poll", int'(fr_op[f0+1]), 'h03);
    chk(rd_n == 3 && rd_got[2] == fdat(24'h000012, 1), "R5 read data chip 1", int'(rd_got[2]),
        int'(fdat(24'h000012, 1)));
  endtask

  task automatic t_erase;
    bit e; int f0 = fr_n;
    do_req(2'd2, 24'h010000, 0, e);
    chk(!e && fr_n == f0 + 2, "R2 erase frames", fr_n - f0, 2);
    chk(fr_op[f0] == 8'h06 && fr_op[f0+1] == 8'hD8, "R1 erase opcode", int'(fr_op[f0+1]), 'hD8);
    chk(fr_addr[f0+1] == 24'h010000 && fr_bytes[f0+1] == 4, "R1 erase address", int'(fr_addr[f0+1]), 'h10000);
    f0 = fr_n;
    do_req(2'd2, 24'h010000, 0, e);
    chk(!e && fr_n == f0 + 3, "R3 second erase frames", fr_n - f0, 3);
    chk(fr_op[f0] == 8'h05 && fr_op[f0+1] == 8'h06 && fr_op[f0+2] == 8'hD8, "R3 poll then enable",
        int'(fr_op[f0]), 'h05);
  endtask

  task automatic t_range;
    bit e; int f0, s0;
    f0 = fr_n; s0 = sel_falls;
    do_req(2'd0, 24'h07FFFE, 4, e);
    chk(e == 1'b1, "R7 read past end", int'(e), 1);
    do_req(2'd0, 24'h000000, 0, e);
    chk(e == 1'b1, "R7 zero length", int'(e), 1);
    do_req(2'd2, 24'h080000, 0, e);
    chk(e == 1'b1, "R7 erase past end", int'(e), 1);
    chk(fr_n == f0 && sel_falls == s0, "R7 no select activity", sel_falls - s0, 0);
    rd_n = 0;
    do_req(2'd0, 24'h07FFFC, 4, e);
    chk(!e && rd_n == 4, "R7 read ending at total", int'(e), 0);
    chk(fr_addr[fr_n-1] == 24'h03FFFC && fr_chip[fr_n-1] == 1, "R9 local address top",
        int'(fr_addr[fr_n-1]), 'h3FFFC);
  endtask

  task automatic t_page;
    bit e; int s0 = sel_falls;
    do_req(2'd1, 24'h0000F0, 17, e);
    chk(e == 1'b1 && sel_falls == s0, "R8 page crossing rejected", int'(e), 1);
    for (int i = 0; i < 16; i++) wq[i] = 8'(8'h80 + i);
    prog_req(24'h0000F0, 16, e);
    chk(!e, "R8 page end accepted", int'(e), 0);
    chk(fr_op[fr_n-1] == 8'h02 && fr_bytes[fr_n-1] == 20, "R6 program length", fr_bytes[fr_n-1], 20);
    chk(pdata[15] == 8'h8F && pdata[0] == 8'h80, "R6 program order", int'(pdata[15]), 'h8F);
  endtask

  task automatic t_rsvd;
    bit e; int s0 = sel_falls;
    do_req(2'd3, 24'h000000, 1, e);
    chk(e == 1'b1 && sel_falls == s0, "R11 reserved op rejected", int'(e), 1);
  endtask

  task automatic t_backpressure;
    bit e;
    rd_n = 0; rd_ready = 1'b0;
    fork
      do_req(2'd0, 24'h040100, 3, e);
      begin
        repeat (300) @(negedge clk);
        chk(rd_valid == 1'b1 && rd_n == 0, "R5 held under backpressure", int'(rd_valid), 1);
        chk(rd_data == fdat(24'h000100, 1), "R5 held byte", int'(rd_data), int'(fdat(24'h000100, 1)));
        rd_ready = 1'b1;
      end
    join
    chk(!e && rd_n == 3, "R5 count after stall", rd_n, 3);
    for (int i = 0; i < 3; i++)
      chk(rd_got[i] == fdat(24'h000100 + 24'(i), 1), "R5 order after stall", int'(rd_got[i]),
          int'(fdat(24'h000100 + 24'(i), 1)));
  endtask

  task automatic t_final;
    chk(hi_min == 2 && hi_max == 2, "R4 sclk high phase", hi_max, 2);
    chk(fill_bad == 0, "R5 fill during read data", fill_bad, 0);
    chk(viol == 0, "R2 R3 protocol violations in model", viol, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0; req_len = '0;
    wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_read_plain;
    t_program;
    t_other_chip;
    t_poll;
    t_erase;
    t_range;
    t_page;
    t_rsvd;
    t_backpressure;
    t_final;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule